// File: doc/BRIEF.md
# Pipelined Bus Transaction Phase Tracker

This block follows several bus transactions at once as each one walks through six ordered phases: arbitration, request, error check, snoop, response and data. Every phase holds at most one transaction, and because each phase listens to its own group of bus signals, a new transaction can move into a phase in the same cycle that the previous occupant moves out. The tracker gives each accepted transaction a small identifier and reports which identifier sits in each phase on every cycle.

The inputs are what a bus observer sees each cycle: an arbitration request with its read/write flag, request packets with a parity bit, the snoop outcome (hit, defer), a typed response code and a data-ready strobe for each 64-bit beat. The outputs are the phase occupants, the retirement events (restart after a parity error, retry or defer, completion with or without failure, completion of the data phase) and which agent drives the data bus while a data phase is active. A retired identifier returns to the pool and can be granted again in the next cycle.

Top module: `bus_phase_tracker`

## Requirements
- R1: After reset no phase is occupied, `full` is low and no retirement event output is asserted.
- R2: When `arb_req` is high, the tracker is not full and the arbitration phase is free or emptying, `arb_gnt` is high in that cycle with `arb_gnt_id` equal to the lowest free identifier; that identifier occupies the arbitration phase (occupancy bit 0) from the next clock edge.
- R3: At most `MAX_OUT` (default 4) transactions are outstanding; while all identifiers are in use `full` is high and `arb_gnt` stays low whatever `arb_req` does.
- R4: The request phase (bit 1) accepts exactly two packets, taken on cycles with `req_pkt_valid` high while it is occupied; after the second packet the transaction moves to the error phase (bit 2). Packets seen while the request phase is empty are ignored.
- R5: Parity is even: a packet is good when the XOR of `req_pkt` and `req_pkt_par` is 0. If either of the two packets was bad, `restart_valid` is high with `restart_id` for the one cycle the transaction spends in the error phase, its identifier is freed and it enters no later phase.
- R6: A transaction that passes the error check moves to the snoop phase (bit 3), waits there until `snoop_valid` is high, records `snoop_hit` and `snoop_defer`, and then moves to the response phase (bit 4).
- R7: In the response phase, on `resp_valid` the code decides the outcome: 0 = no data (completion), 1 = normal data (move to the data phase, bit 5), 2 = retry/defer (`retry_valid`), 3 = hard failure (completion with `rsp_done_fail` high). A snoop defer turns any code into retry/defer. Codes 0, 2 and 3 retire the transaction without a data phase.
- R8: The data phase lasts `DATA_BEATS` (default 4) cycles with `data_ready` high; on the last one `dat_done_valid` is high with `dat_done_id`, and the identifier is freed.
- R9: While the data phase is occupied, `data_src` names the driver: 1 = requester for a write, 2 = snooping agent for a read that hit, 0 = responding agent for a read that missed; it stays constant for the whole data phase.
- R10: Transactions advance strictly in order; a phase keeps its occupant until the next phase can take it, so different transactions sit in different phases at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_req | input | 1 | A requester asks for the bus |
| arb_write | input | 1 | The requested transaction is a write |
| arb_gnt | output | 1 | Request accepted this cycle |
| arb_gnt_id | output | ID_W | Identifier given to the accepted transaction |
| full | output | 1 | All identifiers in use |
| req_pkt_valid | input | 1 | A request packet is on the bus |
| req_pkt | input | PKT_W | Request packet contents |
| req_pkt_par | input | 1 | Even-parity bit of the packet |
| snoop_valid | input | 1 | Snoop outcome is present |
| snoop_hit | input | 1 | A snooper holds a newer copy |
| snoop_defer | input | 1 | The responder chooses to defer |
| resp_valid | input | 1 | Response code is present |
| resp_code | input | 2 | 0 no data, 1 normal data, 2 retry/defer, 3 hard failure |
| data_ready | input | 1 | One data beat completes |
| occ_valid | output | 6 | Phase occupied, bit 0 arbitration to bit 5 data |
| occ_id | output | 6*ID_W | Occupant identifier per phase, phase p at bits p*ID_W |
| restart_valid | output | 1 | Parity failure, transaction must start over |
| restart_id | output | ID_W | Identifier of the restarted transaction |
| retry_valid | output | 1 | Transaction retired by retry or defer |
| retry_id | output | ID_W | Identifier of the retried transaction |
| rsp_done_valid | output | 1 | Completion without a data phase |
| rsp_done_id | output | ID_W | Identifier of that completion |
| rsp_done_fail | output | 1 | The completion was a hard failure |
| dat_done_valid | output | 1 | Data phase finished |
| dat_done_id | output | ID_W | Identifier of the finished data phase |
| data_active | output | 1 | A data phase is in progress |
| data_src | output | 2 | Data driver: 0 responder, 1 requester, 2 snooper |

## Verification
On every cycle the assertions check that the number of occupied phases equals the number of identifiers in use, that every retired identifier was in use, that a waiting snoop occupant stays put, that a non-data response never leads its transaction into the data phase, that a restarted transaction never reaches the snoop phase, that the data driver stays constant and that a data phase lasts until its final beat. Only the scenarios show the identifier values granted and reused, the exact cycle each phase is entered, the two-packet count, the decoding of each response code with and without a snoop defer, the driver chosen for writes, hits and misses, and the ordering of four transactions stacked in the pipeline while the tracker is full.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  localparam int NUM_PHASES = 6;
  localparam int PH_ARB = 0;
  localparam int PH_REQ = 1;
  localparam int PH_ERR = 2;
  localparam int PH_SNP = 3;
  localparam int PH_RSP = 4;
  localparam int PH_DAT = 5;

  typedef enum logic [1:0] {
    RSP_NODATA   = 2'd0,
    RSP_NORMAL   = 2'd1,
    RSP_RETRY    = 2'd2,
    RSP_HARDFAIL = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    SRC_RESPONDER = 2'd0,
    SRC_REQUESTER = 2'd1,
    SRC_SNOOPER   = 2'd2
  } data_src_e;

  // A deferred snoop overrides whatever code the responder presents.
  function automatic rsp_kind_e effective_kind(input logic [1:0] code, input logic deferred);
    if (deferred) return RSP_RETRY;
    return rsp_kind_e'(code);
  endfunction

  function automatic data_src_e pick_source(input logic is_write, input logic hit);
    if (is_write) return SRC_REQUESTER;
    if (hit)      return SRC_SNOOPER;
    return SRC_RESPONDER;
  endfunction

  function automatic logic retires_early(input rsp_kind_e kind);
    return kind != RSP_NORMAL;
  endfunction

endpackage

// File: rtl/bpt_id_pool.sv
module bpt_id_pool #(
  parameter int MAX_OUT = 4,
  parameter int NFREE   = 4,
  localparam int ID_W   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_en,
  output logic [ID_W-1:0]       alloc_id,
  output logic                  full,
  output logic [CNT_W-1:0]      count,
  input  logic [NFREE-1:0]      free_en,
  input  logic [NFREE*ID_W-1:0] free_id
);

  logic [MAX_OUT-1:0] busy_q;
  logic [MAX_OUT-1:0] clr_mask;
  logic [MAX_OUT-1:0] set_mask;
  logic               found;

  always_comb begin
    alloc_id = '0;
    found    = 1'b0;
    for (int i = 0; i < MAX_OUT; i++) begin
      if (!busy_q[i] && !found) begin
        alloc_id = ID_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    clr_mask = '0;
    for (int k = 0; k < NFREE; k++) begin
      if (free_en[k]) clr_mask[free_id[k*ID_W +: ID_W]] = 1'b1;
    end
  end

  always_comb begin
    set_mask = '0;
    if (alloc_en) set_mask[alloc_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~clr_mask) | set_mask;
  end

  assign full  = &busy_q;
  assign count = CNT_W'($countones(busy_q));

  for (genvar k = 0; k < NFREE; k++) begin : g_free_chk
    AST_FREE_WAS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      free_en[k] |-> busy_q[free_id[k*ID_W +: ID_W]]); // R3
  end

endmodule

// File: rtl/bpt_req_stage.sv
module bpt_req_stage #(
  parameter int PKT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             occ,
  input  logic             enter,
  input  logic             pkt_valid,
  input  logic [PKT_W-1:0] pkt,
  input  logic             pkt_par,
  input  logic             out_ready,
  output logic             take,
  output logic             done,
  output logic             bad
);

  logic seen_first_q;
  logic bad_acc_q;
  logic pkt_good;

  assign pkt_good = ~(^{pkt, pkt_par});
  // The second packet is only taken when the error phase can accept it.
  assign take = occ && pkt_valid && (!seen_first_q || out_ready);
  assign done = take && seen_first_q;
  assign bad  = bad_acc_q || !pkt_good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_first_q <= 1'b0;
      bad_acc_q    <= 1'b0;
    end else if (enter) begin
      seen_first_q <= 1'b0;
      bad_acc_q    <= 1'b0;
    end else if (take) begin
      seen_first_q <= !seen_first_q;
      bad_acc_q    <= !seen_first_q ? !pkt_good : 1'b0;
    end
  end

  AST_REQ_EMPTY_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!occ && !enter) |=> !seen_first_q); // R4

endmodule

// File: rtl/bpt_data_stage.sv
module bpt_data_stage #(
  parameter int DATA_BEATS = 4,
  localparam int CW = (DATA_BEATS > 1) ? $clog2(DATA_BEATS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic enter,
  input  logic ready,
  output logic last,
  output logic leave
);

  logic [CW-1:0] beat_q;

  assign last  = (beat_q == CW'(DATA_BEATS - 1));
  assign leave = active && ready && last;

  always_ff @(posedge clk) begin
    if (!rst_n)                beat_q <= '0;
    else if (enter)            beat_q <= '0;
    else if (active && ready)  beat_q <= beat_q + 1'b1;
  end

  AST_DAT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ready && !last) |=> active); // R8

endmodule

// File: rtl/bus_phase_tracker.sv
module bus_phase_tracker
  import bpt_pkg::*;
#(
  parameter int MAX_OUT    = 4,
  parameter int PKT_W      = 32,
  parameter int DATA_BEATS = 4,
  localparam int ID_W      = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arb_req,
  input  logic                       arb_write,
  output logic                       arb_gnt,
  output logic [ID_W-1:0]            arb_gnt_id,
  output logic                       full,
  input  logic                       req_pkt_valid,
  input  logic [PKT_W-1:0]           req_pkt,
  input  logic                       req_pkt_par,
  input  logic                       snoop_valid,
  input  logic                       snoop_hit,
  input  logic                       snoop_defer,
  input  logic                       resp_valid,
  input  logic [1:0]                 resp_code,
  input  logic                       data_ready,
  output logic [NUM_PHASES-1:0]      occ_valid,
  output logic [NUM_PHASES*ID_W-1:0] occ_id,
  output logic                       restart_valid,
  output logic [ID_W-1:0]            restart_id,
  output logic                       retry_valid,
  output logic [ID_W-1:0]            retry_id,
  output logic                       rsp_done_valid,
  output logic [ID_W-1:0]            rsp_done_id,
  output logic                       rsp_done_fail,
  output logic                       dat_done_valid,
  output logic [ID_W-1:0]            dat_done_id,
  output logic                       data_active,
  output logic [1:0]                 data_src
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam int NFREE = 4;

  // Per-phase occupant state
  logic [NUM_PHASES-1:0] v_q;
  logic [ID_W-1:0]       id_q [NUM_PHASES];
  logic [PH_RSP:0]       wr_q;
  logic                  err_bad_q;
  logic                  rsp_hit_q;
  logic                  rsp_def_q;
  data_src_e             dat_src_q;

  // Named movement events
  logic      arb_move, arb_free;
  logic      req_take, req_done, req_bad, req_free;
  logic      err_fail, err_pass, err_free;
  logic      snp_fire, snp_free;
  rsp_kind_e rsp_kind;
  logic      rsp_fire, rsp_to_dat, rsp_free;
  logic      dat_last, dat_leave, dat_free;

  logic [ID_W-1:0]       alloc_id;
  logic                  pool_full;
  logic [CNT_W-1:0]      pool_count;
  logic [NFREE-1:0]      free_en;
  logic [NFREE*ID_W-1:0] free_id;

  // Ready chain, evaluated from the data phase backwards
  assign dat_free   = !v_q[PH_DAT] || dat_leave;
  assign rsp_kind   = effective_kind(resp_code, rsp_def_q);
  assign rsp_fire   = v_q[PH_RSP] && resp_valid && (retires_early(rsp_kind) || dat_free);
  assign rsp_to_dat = rsp_fire && (rsp_kind == RSP_NORMAL);
  assign rsp_free   = !v_q[PH_RSP] || rsp_fire;
  assign snp_fire   = v_q[PH_SNP] && snoop_valid && rsp_free;
  assign snp_free   = !v_q[PH_SNP] || snp_fire;
  assign err_fail   = v_q[PH_ERR] && err_bad_q;
  assign err_pass   = v_q[PH_ERR] && !err_bad_q && snp_free;
  assign err_free   = !v_q[PH_ERR] || err_fail || err_pass;
  assign req_free   = !v_q[PH_REQ] || req_done;
  assign arb_move   = v_q[PH_ARB] && req_free;
  assign arb_free   = !v_q[PH_ARB] || arb_move;
  assign arb_gnt    = arb_req && !pool_full && arb_free;

  bpt_id_pool #(.MAX_OUT(MAX_OUT), .NFREE(NFREE)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (arb_gnt),
    .alloc_id (alloc_id),
    .full     (pool_full),
    .count    (pool_count),
    .free_en  (free_en),
    .free_id  (free_id)
  );

  bpt_req_stage #(.PKT_W(PKT_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ       (v_q[PH_REQ]),
    .enter     (arb_move),
    .pkt_valid (req_pkt_valid),
    .pkt       (req_pkt),
    .pkt_par   (req_pkt_par),
    .out_ready (err_free),
    .take      (req_take),
    .done      (req_done),
    .bad       (req_bad)
  );

  bpt_data_stage #(.DATA_BEATS(DATA_BEATS)) u_dat (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (v_q[PH_DAT]),
    .enter  (rsp_to_dat),
    .ready  (data_ready),
    .last   (dat_last),
    .leave  (dat_leave)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= '0;
      wr_q      <= '0;
      err_bad_q <= 1'b0;
      rsp_hit_q <= 1'b0;
      rsp_def_q <= 1'b0;
      dat_src_q <= SRC_RESPONDER;
      for (int s = 0; s < NUM_PHASES; s++) id_q[s] <= '0;
    end else begin
      if (arb_gnt) begin
        v_q[PH_ARB]  <= 1'b1;
        id_q[PH_ARB] <= alloc_id;
        wr_q[PH_ARB] <= arb_write;
      end else if (arb_move) begin
        v_q[PH_ARB]  <= 1'b0;
      end

      if (arb_move) begin
        v_q[PH_REQ]  <= 1'b1;
        id_q[PH_REQ] <= id_q[PH_ARB];
        wr_q[PH_REQ] <= wr_q[PH_ARB];
      end else if (req_done) begin
        v_q[PH_REQ]  <= 1'b0;
      end

      if (req_done) begin
        v_q[PH_ERR]  <= 1'b1;
        id_q[PH_ERR] <= id_q[PH_REQ];
        wr_q[PH_ERR] <= wr_q[PH_REQ];
        err_bad_q    <= req_bad;
      end else if (err_fail || err_pass) begin
        v_q[PH_ERR]  <= 1'b0;
      end

      if (err_pass) begin
        v_q[PH_SNP]  <= 1'b1;
        id_q[PH_SNP] <= id_q[PH_ERR];
        wr_q[PH_SNP] <= wr_q[PH_ERR];
      end else if (snp_fire) begin
        v_q[PH_SNP]  <= 1'b0;
      end

      if (snp_fire) begin
        v_q[PH_RSP]  <= 1'b1;
        id_q[PH_RSP] <= id_q[PH_SNP];
        wr_q[PH_RSP] <= wr_q[PH_SNP];
        rsp_hit_q    <= snoop_hit;
        rsp_def_q    <= snoop_defer;
      end else if (rsp_fire) begin
        v_q[PH_RSP]  <= 1'b0;
      end

      if (rsp_to_dat) begin
        v_q[PH_DAT]  <= 1'b1;
        id_q[PH_DAT] <= id_q[PH_RSP];
        dat_src_q    <= pick_source(wr_q[PH_RSP], rsp_hit_q);
      end else if (dat_leave) begin
        v_q[PH_DAT]  <= 1'b0;
      end
    end
  end

  // Retirement events
  assign restart_valid  = err_fail;
  assign restart_id     = id_q[PH_ERR];
  assign retry_valid    = rsp_fire && (rsp_kind == RSP_RETRY);
  assign retry_id       = id_q[PH_RSP];
  assign rsp_done_valid = rsp_fire && ((rsp_kind == RSP_NODATA) || (rsp_kind == RSP_HARDFAIL));
  assign rsp_done_id    = id_q[PH_RSP];
  assign rsp_done_fail  = rsp_done_valid && (rsp_kind == RSP_HARDFAIL);
  assign dat_done_valid = dat_leave;
  assign dat_done_id    = id_q[PH_DAT];

  assign free_en = {dat_leave, rsp_done_valid, retry_valid, restart_valid};
  assign free_id = {id_q[PH_DAT], id_q[PH_RSP], id_q[PH_RSP], id_q[PH_ERR]};

  assign arb_gnt_id  = alloc_id;
  assign full        = pool_full;
  assign occ_valid   = v_q;
  assign data_active = v_q[PH_DAT];
  assign data_src    = dat_src_q;

  for (genvar s = 0; s < NUM_PHASES; s++) begin : g_occ
    assign occ_id[s*ID_W +: ID_W] = id_q[s];
  end

  AST_OCC_MATCH_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(v_q) == int'(pool_count)); // R3

  AST_SNOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[PH_SNP] && !snoop_valid) |=> (v_q[PH_SNP] && $stable(id_q[PH_SNP]))); // R10

  AST_NO_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[PH_RSP] && resp_valid && (resp_code != RSP_NORMAL))
      |=> !(v_q[PH_DAT] && (id_q[PH_DAT] == $past(id_q[PH_RSP])))); // R7

  AST_RESTART_NO_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |=> !(v_q[PH_SNP] && (id_q[PH_SNP] == $past(restart_id)))); // R5

  AST_SRC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[PH_DAT] && !data_ready) |=> $stable(data_src)); // R9

endmodule

// File: tb/bus_phase_tracker_test.sv
`timescale 1ns/1ps
module bus_phase_tracker_test;

  localparam int MAX_OUT    = 4;
  localparam int PKT_W      = 32;
  localparam int DATA_BEATS = 4;
  localparam int ID_W       = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              arb_req, arb_write, arb_gnt, full;
  logic [ID_W-1:0]   arb_gnt_id;
  logic              req_pkt_valid, req_pkt_par;
  logic [PKT_W-1:0]  req_pkt;
  logic              snoop_valid, snoop_hit, snoop_defer;
  logic              resp_valid;
  logic [1:0]        resp_code;
  logic              data_ready;
  logic [5:0]        occ_valid;
  logic [6*ID_W-1:0] occ_id;
  logic              restart_valid, retry_valid, rsp_done_valid, rsp_done_fail;
  logic              dat_done_valid, data_active;
  logic [ID_W-1:0]   restart_id, retry_id, rsp_done_id, dat_done_id;
  logic [1:0]        data_src;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [PKT_W-1:0] pkt_seed = 32'h1357_9BDF;

  always #10 clk = ~clk;

  bus_phase_tracker #(.MAX_OUT(MAX_OUT), .PKT_W(PKT_W), .DATA_BEATS(DATA_BEATS)) uut (
    .clk(clk), .rst_n(rst_n),
    .arb_req(arb_req), .arb_write(arb_write), .arb_gnt(arb_gnt), .arb_gnt_id(arb_gnt_id),
    .full(full),
    .req_pkt_valid(req_pkt_valid), .req_pkt(req_pkt), .req_pkt_par(req_pkt_par),
    .snoop_valid(snoop_valid), .snoop_hit(snoop_hit), .snoop_defer(snoop_defer),
    .resp_valid(resp_valid), .resp_code(resp_code), .data_ready(data_ready),
    .occ_valid(occ_valid), .occ_id(occ_id),
    .restart_valid(restart_valid), .restart_id(restart_id),
    .retry_valid(retry_valid), .retry_id(retry_id),
    .rsp_done_valid(rsp_done_valid), .rsp_done_id(rsp_done_id), .rsp_done_fail(rsp_done_fail),
    .dat_done_valid(dat_done_valid), .dat_done_id(dat_done_id),
    .data_active(data_active), .data_src(data_src)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [ID_W-1:0] phase_id(input int p);
    return occ_id[p*ID_W +: ID_W];
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    arb_req = 0; arb_write = 0; req_pkt_valid = 0; req_pkt = '0; req_pkt_par = 0;
    snoop_valid = 0; snoop_hit = 0; snoop_defer = 0; resp_valid = 0; resp_code = 0;
    data_ready = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    step();
  endtask

  task automatic do_arb(input logic wr, input logic [ID_W-1:0] exp_id);
    arb_req = 1; arb_write = wr;
    #1;
    chk("R2 grant", arb_gnt, 1);
    chk("R2 grant id", arb_gnt_id, exp_id);
    step();
    arb_req = 0;
    chk("R2 arb occupied", occ_valid[0], 1);
    chk("R2 arb occupant", phase_id(0), exp_id);
  endtask

  task automatic send_pkt(input logic bad);
    pkt_seed = {pkt_seed[30:0], pkt_seed[31] ^ pkt_seed[21] ^ pkt_seed[1]};
    req_pkt = pkt_seed;
    req_pkt_par = (^pkt_seed) ^ bad;
    req_pkt_valid = 1;
    step();
    req_pkt_valid = 0;
  endtask

  // Full life of one transaction on an otherwise empty tracker.
  task automatic run_txn(input logic wr, input logic hit, input logic defer, input logic [1:0] code);
    logic [1:0] eff;
    logic [1:0] exp_src;
    eff = defer ? 2'd2 : code;
    exp_src = wr ? 2'd1 : (hit ? 2'd2 : 2'd0);
    do_reset();
    do_arb(wr, 0);
    step();
    chk("R4 in request phase", occ_valid, 6'b000010);
    send_pkt(0);
    chk("R4 still requesting after one packet", occ_valid, 6'b000010);
    send_pkt(0);
    chk("R4 error phase after two packets", occ_valid, 6'b000100);
    chk("R5 no restart on good parity", restart_valid, 0);
    step();
    chk("R6 snoop phase", occ_valid, 6'b001000);
    step();
    chk("R6 snoop waits", occ_valid, 6'b001000);
    snoop_valid = 1; snoop_hit = hit; snoop_defer = defer;
    step();
    snoop_valid = 0; snoop_hit = 0; snoop_defer = 0;
    chk("R6 response phase", occ_valid, 6'b010000);
    resp_valid = 1; resp_code = code;
    #1;
    chk("R7 retry event", retry_valid, eff == 2'd2);
    chk("R7 completion event", rsp_done_valid, (eff == 2'd0) || (eff == 2'd3));
    chk("R7 failure flag", rsp_done_fail, eff == 2'd3);
    step();
    resp_valid = 0;
    if (eff == 2'd1) begin
      chk("R7 data phase entered", occ_valid, 6'b100000);
      chk("R9 data driver", data_src, exp_src);
      for (int b = 0; b < DATA_BEATS; b++) begin
        data_ready = 1;
        #1;
        chk("R8 data done on last beat", dat_done_valid, b == DATA_BEATS - 1);
        step();
        data_ready = 0;
        if (b < DATA_BEATS - 1) chk("R9 driver held", data_src, exp_src);
      end
      chk("R8 data phase left", occ_valid, 6'b000000);
    end else begin
      chk("R7 no data phase", occ_valid, 6'b000000);
    end
    do_arb(0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 no occupants", occ_valid, 0);
    chk("R1 not full", full, 0);
    chk("R1 no restart", restart_valid, 0);
    chk("R1 no retry", retry_valid, 0);
    chk("R1 no completion", rsp_done_valid, 0);
    chk("R1 no data done", dat_done_valid, 0);
  endtask

  task automatic t_parity();
    do_reset();
    do_arb(0, 0);
    step();
    send_pkt(1);
    send_pkt(0);
    chk("R5 restart raised", restart_valid, 1);
    chk("R5 restart id", restart_id, 0);
    step();
    chk("R5 no later phase", occ_valid, 0);
    chk("R5 restart one cycle", restart_valid, 0);
    do_arb(0, 0);
    step();
    send_pkt(0);
    send_pkt(1);
    chk("R5 restart on second packet", restart_valid, 1);
  endtask

  task automatic t_ignored_pkts();
    do_reset();
    send_pkt(0);
    send_pkt(0);
    chk("R4 stray packets no occupant", occ_valid, 0);
    do_arb(1, 0);
    step();
    send_pkt(0);
    chk("R4 stray packets not counted", occ_valid, 6'b000010);
  endtask

  task automatic t_full();
    do_reset();
    do_arb(0, 0);
    step();
    send_pkt(0);
    send_pkt(0);
    step();
    do_arb(0, 1);
    step();
    send_pkt(0);
    send_pkt(0);
    step();
    chk("R10 error phase blocked by snoop", occ_valid, 6'b001100);
    do_arb(0, 2);
    step();
    send_pkt(0);
    do_arb(0, 3);
    step();
    chk("R3 full flag", full, 1);
    chk("R10 four phases occupied", occ_valid, 6'b001111);
    chk("R10 arb occupant", phase_id(0), 3);
    chk("R10 req occupant", phase_id(1), 2);
    chk("R10 err occupant", phase_id(2), 1);
    chk("R10 snp occupant", phase_id(3), 0);
    arb_req = 1;
    #1;
    chk("R3 no grant while full", arb_gnt, 0);
    step();
    arb_req = 0;
    chk("R3 no new occupant", occ_valid, 6'b001111);
    snoop_valid = 1;
    step();
    snoop_valid = 0;
    chk("R10 in-order advance", occ_valid, 6'b011011);
    chk("R10 rsp occupant", phase_id(4), 0);
    chk("R10 snp occupant after move", phase_id(3), 1);
  endtask

  initial begin
    t_reset();
    run_txn(0, 0, 0, 2'd1);
    run_txn(1, 0, 0, 2'd1);
    run_txn(0, 1, 0, 2'd1);
    run_txn(0, 0, 0, 2'd0);
    run_txn(0, 0, 0, 2'd2);
    run_txn(0, 0, 0, 2'd3);
    run_txn(0, 0, 1, 2'd1);
    t_parity();
    t_ignored_pkts();
    t_full();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule